// File: doc/BRIEF.md
# Branch History Ring Buffer

This block keeps a short circular history of control-flow changes taken by a processor core. Each accepted branch event stores a source word and a target word. The source word packs three status flags above a truncated source address. A select register can drop chosen branch classes and either privilege side before anything is stored. An enable bit turns recording on. A freeze bit makes a performance interrupt halt recording until software acknowledges it.

Software reads the history relative to the newest record. It presents an index `i` and gets back the record `i` positions older than the one the top pointer names. The top pointer is also visible directly. A clear pulse wipes every slot and rewinds the pointer. An optional call-stack mode turns the ring into a return stack: calls push, near returns pop, and all other branch kinds leave it alone.

The depth is a parameter and must be 4, 8, 16 or 32. Wrap-around is done by masking the index to the depth.

Top module: `lbr_ring`

## Requirements
- R1: After reset the top pointer is 0, `frozen` is low, and every slot reads back as zero on all three read outputs.
- R2: With call-stack mode off, each accepted event first advances the top pointer by one modulo DEPTH. It then writes the record into the slot the new pointer names. Reading index i returns slot (top − i) modulo DEPTH, so index 0 is always the newest record.
- R3: `br_kind` encodes 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch, 7 other. For kinds 0 to 6, select bit (kind + 2) set drops the event. Kind 7 is never dropped by a kind bit.
- R4: Select bit 0 set drops events whose target is ring 0 (`br_kernel` high). Select bit 1 set drops events whose target is not ring 0.
- R5: While the enable bit is low, no event changes the pointer or any slot.
- R6: While the enable bit and the freeze bit are both set, a `pmi` pulse raises `frozen` on the next cycle. While `frozen` is high, events are ignored. `pmi_ack` lowers `frozen` when no new freezing interrupt arrives in the same cycle. A `pmi` with the freeze bit clear has no effect. An event in the same cycle as the freezing `pmi` is still recorded.
- R7: With select bit 9 set (call-stack mode), an accepted relative or indirect call pushes a record as in R2. An accepted near return moves the pointer back by one and leaves slot contents as they are. All other kinds change nothing.
- R8: In call-stack mode, a near return that arrives when no records are held leaves the pointer unchanged. The number of records held rises with each push, up to DEPTH, and falls with each pop.
- R9: The stored source word holds mispredict in bit 63, in-transaction in bit 62 and abort in bit 61, with the 61-bit source address in bits 60:0. `rd_src_raw` returns this word. `rd_src_addr` returns bits 60:0 sign-extended from bit 60 to 64 bits.
- R10: `clear` zeroes every slot, the pointer and the held count on the next cycle. It takes precedence over an event in the same cycle.
- R11: Configuration written with `cfg_we` takes effect from the following cycle. An event in the write cycle uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the select, enable and freeze settings |
| cfg_sel | input | 10 | Suppress bits 8:0, call-stack mode bit 9 |
| cfg_en | input | 1 | Recording enable |
| cfg_frz | input | 1 | Freeze on performance interrupt |
| br_valid | input | 1 | A branch event is present |
| br_from | input | 61 | Branch source address |
| br_to | input | 64 | Branch target address |
| br_kind | input | 3 | Branch class code (see R3) |
| br_kernel | input | 1 | Target is ring 0 |
| br_mispred | input | 1 | Branch was mispredicted |
| br_intx | input | 1 | Branch occurred inside a transaction |
| br_abort | input | 1 | Event is a transaction abort |
| pmi | input | 1 | Performance interrupt raised |
| pmi_ack | input | 1 | Software acknowledge of the interrupt |
| clear | input | 1 | Wipe all records |
| rd_idx | input | 4 | Age of the record to read (0 = newest) |
| rd_src_raw | output | 64 | Packed source word of the selected record |
| rd_src_addr | output | 64 | Sign-extended source address of the selected record |
| rd_to | output | 64 | Target of the selected record |
| tos | output | 4 | Top pointer: slot of the most recent record |
| frozen | output | 1 | Recording halted by an interrupt |

## Verification
Plain recording runs far past DEPTH events. This shows whether the pointer wraps and whether reads index relative to the newest record rather than to slot 0.

Each kind and each privilege side is then sent against single select bits. A wrong bit-to-class mapping keeps a class it should drop, or drops one it should keep. Call-stack runs mix calls, returns and jumps, and include returns past empty. These separate push/pop direction from the empty guard.

A long random phase toggles enable, freeze, interrupts, acknowledges and clears against a behavioural model. It exposes any wrong precedence between clear, freeze and recording.

// File: rtl/lbr_ring.sv
`timescale 1ns/1ps
module lbr_ring #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 61,
  parameter int WORD_W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [9:0]               cfg_sel,
  input  logic                     cfg_en,
  input  logic                     cfg_frz,
  input  logic                     br_valid,
  input  logic [ADDR_W-1:0]        br_from,
  input  logic [WORD_W-1:0]        br_to,
  input  logic [2:0]               br_kind,
  input  logic                     br_kernel,
  input  logic                     br_mispred,
  input  logic                     br_intx,
  input  logic                     br_abort,
  input  logic                     pmi,
  input  logic                     pmi_ack,
  input  logic                     clear,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [WORD_W-1:0]        rd_src_raw,
  output logic [WORD_W-1:0]        rd_src_addr,
  output logic [WORD_W-1:0]        rd_to,
  output logic [$clog2(DEPTH)-1:0] tos,
  output logic                     frozen
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW:0] CNT_FULL = (IW+1)'(DEPTH);
  localparam logic [2:0] K_RCALL = 3'd1, K_ICALL = 3'd2, K_RET = 3'd3, K_OTHER = 3'd7;

  logic [WORD_W-1:0] src_q [DEPTH];
  logic [WORD_W-1:0] dst_q [DEPTH];
  logic [9:0]        sel_q;
  logic              en_q, frz_q, frozen_q;
  logic [IW-1:0]     tos_q;
  logic [IW:0]       cnt_q;

  logic kind_sup, priv_sup, live, push, pop;
  logic [IW-1:0] wr_ptr, rd_slot;

  always_comb kind_sup = (br_kind == K_OTHER) ? 1'b0 : sel_q[4'(br_kind) + 4'd2];
  assign priv_sup = br_kernel ? sel_q[0] : sel_q[1];
  assign live     = br_valid & en_q & ~frozen_q & ~clear & ~kind_sup & ~priv_sup;
  assign push     = live & (~sel_q[9] | br_kind == K_RCALL | br_kind == K_ICALL);
  assign pop      = live & sel_q[9] & (br_kind == K_RET) & (cnt_q != '0);
  assign wr_ptr   = tos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      en_q     <= 1'b0;
      frz_q    <= 1'b0;
      frozen_q <= 1'b0;
      tos_q    <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      if (cfg_we) begin
        sel_q <= cfg_sel;
        en_q  <= cfg_en;
        frz_q <= cfg_frz;
      end
      if (pmi & frz_q & en_q) frozen_q <= 1'b1;
      else if (pmi_ack)       frozen_q <= 1'b0;
      if (clear) begin
        tos_q <= '0;
        cnt_q <= '0;
        for (int i = 0; i < DEPTH; i++) begin
          src_q[i] <= '0;
          dst_q[i] <= '0;
        end
      end else if (push) begin
        src_q[wr_ptr] <= {br_mispred, br_intx, br_abort, br_from};
        dst_q[wr_ptr] <= br_to;
        tos_q         <= wr_ptr;
        if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
      end else if (pop) begin
        tos_q <= tos_q - 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign rd_slot     = tos_q - rd_idx;
  assign rd_src_raw  = src_q[rd_slot];
  assign rd_src_addr = {{(WORD_W-ADDR_W){rd_src_raw[ADDR_W-1]}}, rd_src_raw[ADDR_W-1:0]};
  assign rd_to       = dst_q[rd_slot];
  assign tos         = tos_q;
  assign frozen      = frozen_q;

  p_plain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && en_q && !frozen_q && !clear && sel_q == 10'd0) |=> tos_q == $past(tos_q) + 1'b1);
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clear) |=> $stable(tos_q));
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !clear) |=> $stable(tos_q));
  p_freeze_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pmi && frz_q && en_q) |=> frozen_q);
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pmi_ack && !(pmi && frz_q && en_q)) |=> !frozen_q);
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && sel_q[9] && br_kind == K_RET && !clear) |=> $stable(tos_q));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (tos_q == '0 && cnt_q == '0));
endmodule

// File: tb/tb_lbr_ring.sv
`timescale 1ns/1ps
module tb_lbr_ring;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we, cfg_en, cfg_frz, br_valid, br_kernel, br_mispred, br_intx, br_abort;
  logic pmi, pmi_ack, clear;
  logic [9:0]  cfg_sel;
  logic [60:0] br_from;
  logic [63:0] br_to;
  logic [2:0]  br_kind;
  logic [3:0]  rd_idx;
  logic [63:0] rd_src_raw, rd_src_addr, rd_to;
  logic [3:0]  tos;
  logic        frozen;

  lbr_ring #(.DEPTH(D), .ADDR_W(61), .WORD_W(64)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_frz(cfg_frz), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
    .br_kind(br_kind), .br_kernel(br_kernel), .br_mispred(br_mispred),
    .br_intx(br_intx), .br_abort(br_abort), .pmi(pmi), .pmi_ack(pmi_ack),
    .clear(clear), .rd_idx(rd_idx), .rd_src_raw(rd_src_raw),
    .rd_src_addr(rd_src_addr), .rd_to(rd_to), .tos(tos), .frozen(frozen));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  string cur_req = "R1";

  logic [63:0] msrc [D];
  logic [63:0] mdst [D];
  int mtos, mcnt;
  bit mfroz, men, mfrz;
  logic [9:0] msel;

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic idle();
    cfg_we = 0; br_valid = 0; pmi = 0; pmi_ack = 0; clear = 0;
    br_kind = 3'd0; br_kernel = 0; br_mispred = 0; br_intx = 0; br_abort = 0;
    br_from = '0; br_to = '0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < D; i++) begin msrc[i] = '0; mdst[i] = '0; end
    mtos = 0; mcnt = 0; mfroz = 0; men = 0; mfrz = 0; msel = '0;
  endtask

  task automatic model_step();
    int k;
    bit sup, live, push, pop;
    k = int'(br_kind);
    sup = (br_kernel ? msel[0] : msel[1]) || (k <= 6 && msel[k+2]);
    live = br_valid && men && !mfroz && !clear && !sup;
    push = live && (!msel[9] || k == 1 || k == 2);
    pop  = live && msel[9] && k == 3 && mcnt > 0;
    if (clear) begin
      for (int i = 0; i < D; i++) begin msrc[i] = '0; mdst[i] = '0; end
      mtos = 0; mcnt = 0;
    end else if (push) begin
      mtos = (mtos + 1) % D;
      msrc[mtos] = {br_mispred, br_intx, br_abort, br_from};
      mdst[mtos] = br_to;
      if (mcnt < D) mcnt++;
    end else if (pop) begin
      mtos = (mtos + D - 1) % D;
      mcnt--;
    end
    if (pmi && mfrz && men) mfroz = 1;
    else if (pmi_ack) mfroz = 0;
    if (cfg_we) begin msel = cfg_sel; men = cfg_en; mfrz = cfg_frz; end
  endtask

  task automatic compare_now();
    int slot;
    logic [63:0] raw;
    slot = (mtos - int'(rd_idx)) & (D - 1);
    raw = msrc[slot];
    chk(cur_req, "tos", 64'(tos), 64'(mtos));
    chk(cur_req, "frozen", 64'(frozen), 64'(mfroz));
    chk(cur_req, "src_raw", rd_src_raw, raw);
    chk(cur_req, "src_addr", rd_src_addr, {{3{raw[60]}}, raw[60:0]});
    chk(cur_req, "to", rd_to, mdst[slot]);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #2;
    compare_now();
    rd_idx = rd_idx + 1'b1;
    idle();
  endtask

  task automatic sweep();
    for (int i = 0; i < D; i++) begin
      rd_idx = 4'(i);
      #0.2;
      compare_now();
    end
  endtask

  task automatic set_cfg(logic [9:0] s, bit e, bit f);
    cfg_we = 1; cfg_sel = s; cfg_en = e; cfg_frz = f;
    tick();
  endtask

  task automatic branch(logic [2:0] k, bit kern, logic [60:0] f, logic [63:0] t);
    br_valid = 1; br_kind = k; br_kernel = kern; br_from = f; br_to = t;
    tick();
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] saved;
    idle(); cfg_sel = '0; cfg_en = 0; cfg_frz = 0; rd_idx = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #4 rst_n = 1;
    #0.5;
    // R1 reset state
    cur_req = "R1";
    chk("R1", "tos after reset", 64'(tos), 64'd0);
    chk("R1", "frozen after reset", 64'(frozen), 64'd0);
    sweep();

    // R2 plain recording and wrap
    cur_req = "R2";
    set_cfg(10'd0, 1, 0);
    for (int i = 0; i < 5; i++) branch(3'(i), i[0], 61'(32'h1000 + i), 64'h2000 + 64'(i));
    chk("R2", "tos after five", 64'(tos), 64'd5);
    sweep();
    for (int i = 0; i < 3*D; i++) branch(3'(i % 8), i[1], 61'({$urandom, $urandom}), {$urandom, $urandom});
    sweep();

    // R9 flag packing and sign extension
    cur_req = "R9";
    br_mispred = 1; br_abort = 1;
    branch(3'd4, 0, {1'b1, 60'h123}, 64'hABCD);
    rd_idx = 0; #0.2;
    chk("R9", "flag bits", 64'(rd_src_raw[63:61]), 64'b101);
    chk("R9", "sign-extended addr", rd_src_addr, {4'hF, 60'h123});
    sweep();

    // R3 kind suppression
    cur_req = "R3";
    for (int b = 2; b <= 8; b++) begin
      set_cfg(10'(1 << b), 1, 0);
      for (int k = 0; k < 8; k++) branch(3'(k), k[0], 61'(k * 7 + b), 64'(b * 100 + k));
    end
    set_cfg(10'h1FC, 1, 0);
    saved = tos;
    branch(3'd0, 0, 61'h55, 64'h66);
    chk("R3", "conditional dropped", 64'(tos), 64'(saved));
    branch(3'd7, 0, 61'h77, 64'h88);
    chk("R3", "kind 7 kept", 64'(tos), 64'(saved + 1'b1));
    sweep();

    // R4 privilege suppression
    cur_req = "R4";
    set_cfg(10'd1, 1, 0);
    for (int i = 0; i < 6; i++) branch(3'd5, i[0], 61'(i + 300), 64'(i));
    set_cfg(10'd2, 1, 0);
    for (int i = 0; i < 6; i++) branch(3'd5, i[0], 61'(i + 400), 64'(i));
    sweep();

    // R5 disabled
    cur_req = "R5";
    set_cfg(10'd0, 0, 0);
    saved = tos;
    for (int i = 0; i < 5; i++) branch(3'd1, 0, 61'(i + 500), 64'(i));
    chk("R5", "tos while disabled", 64'(tos), 64'(saved));
    sweep();

    // R11 config timing: event in write cycle uses old (disabled) setting
    cur_req = "R11";
    cfg_we = 1; cfg_sel = 10'd0; cfg_en = 1; cfg_frz = 1;
    br_valid = 1; br_kind = 3'd5; br_from = 61'h999;
    tick();
    chk("R11", "event in write cycle", 64'(tos), 64'(saved));

    // R6 freeze
    cur_req = "R6";
    pmi = 1; br_valid = 1; br_kind = 3'd6; br_from = 61'h600;
    tick();
    chk("R6", "frozen after pmi", 64'(frozen), 64'd1);
    saved = tos;
    for (int i = 0; i < 4; i++) branch(3'd0, 0, 61'(i + 700), 64'(i));
    chk("R6", "tos while frozen", 64'(tos), 64'(saved));
    pmi_ack = 1; tick();
    chk("R6", "released by ack", 64'(frozen), 64'd0);
    branch(3'd0, 0, 61'h800, 64'h801);
    set_cfg(10'd0, 1, 0);
    pmi = 1; tick();
    chk("R6", "pmi without freeze bit", 64'(frozen), 64'd0);
    sweep();

    // R10 clear beats event
    cur_req = "R10";
    clear = 1; br_valid = 1; br_kind = 3'd0; br_from = 61'h42;
    tick();
    chk("R10", "tos after clear", 64'(tos), 64'd0);
    sweep();

    // R7 / R8 call-stack mode
    cur_req = "R7";
    set_cfg(10'h200, 1, 0);
    branch(3'd1, 0, 61'h10, 64'h11);
    branch(3'd2, 0, 61'h20, 64'h21);
    branch(3'd5, 0, 61'h30, 64'h31);
    branch(3'd1, 1, 61'h40, 64'h41);
    chk("R7", "three pushes", 64'(tos), 64'd3);
    branch(3'd3, 0, 61'h50, 64'h51);
    chk("R7", "pop moves back", 64'(tos), 64'd2);
    sweep();
    cur_req = "R8";
    for (int i = 0; i < 4; i++) branch(3'd3, 0, 61'h60, 64'h61);
    chk("R8", "pop past empty", 64'(tos), 64'd0);
    for (int i = 0; i < D + 3; i++) branch(3'd2, 0, 61'(i + 900), 64'(i));
    for (int i = 0; i < D + 3; i++) branch(3'd3, 0, 61'h1, 64'h1);
    sweep();

    // mixed random traffic
    cur_req = "R2/R6/R10 random";
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 4) begin
        cfg_we = 1;
        cfg_sel = ($urandom % 3 == 0) ? 10'h200 : 10'($urandom & 32'h3);
        cfg_en = ($urandom % 6) != 0; cfg_frz = $urandom % 2;
      end
      br_valid = ($urandom % 4) != 0;
      br_kind = 3'($urandom); br_kernel = $urandom % 2;
      br_from = 61'({$urandom, $urandom}); br_to = {$urandom, $urandom};
      br_mispred = $urandom % 2; br_intx = $urandom % 2; br_abort = $urandom % 2;
      pmi = ($urandom % 40) == 0; pmi_ack = ($urandom % 15) == 0;
      clear = ($urandom % 150) == 0;
      tick();
    end
    sweep();

    summary();
    $finish;
  end
endmodule